// File: doc/BRIEF.md
# Receive Message Queue for a CAN Controller

This block sits between the receive side of a CAN controller and the host. The receive side pushes the bytes of each accepted message, one per clock. A frame-end strobe closes the message. The queue counts the bytes of the open message itself, so the footprint it records is always the number of bytes that actually reached storage. A remote-request message holds only its frame-information and identifier bytes. The DLC value inside its header byte is kept untouched as data, and the message occupies only the bytes that were written.

Bytes sit in one ring and per-message records sit in a second ring. Each record holds the stored length and an overrun flag. The host reads any byte of the oldest message by giving an offset from its first byte. It sees that message's length and overrun flag, and it issues a release that drops the whole message in one cycle. If the byte ring fills while a message is open, the remaining bytes are thrown away and the message is marked as overrun. If the record ring is full when a message closes, the whole message is withdrawn.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset, `byte_count` and `msg_count` are 0, `fifo_empty` is 1, and `rd_byte`, `head_len` and `head_ovr` are 0.
- R2: One cycle after `rd_idx` is applied, `rd_byte` shows the byte at offset `rd_idx` from the first byte of the oldest stored message. Bytes come out in the order they were written.
- R3: A `frame_end` pulse closes the open message. `msg_count` rises by one and the record holds the number of bytes stored for that message. A byte written in the same cycle as `frame_end` belongs to the closing message.
- R4: A release of a non-empty queue lowers `byte_count` by the oldest message's length and `msg_count` by one. The next message then becomes the oldest.
- R5: A release while `msg_count` is 0 changes neither count.
- R6: While `byte_count` is 64, written bytes are discarded and the count stays at 64. The open message is recorded with overrun flag 1 and a length equal to the bytes it actually stored.
- R7: A message that lost no bytes is recorded with overrun flag 0.
- R8: If `msg_count` is 32 when `frame_end` arrives, the closing message is discarded. Its bytes leave `byte_count` and `msg_count` stays at 32.
- R9: While `msg_count` is 0, `rd_byte`, `head_len` and `head_ovr` read as 0.
- R10: Both pointer pairs wrap around their rings. Over long mixed traffic, the counts, the head record and the bytes read stay correct.
- R11: A write and a release in the same cycle both take effect. The count changes by one minus the released length.
- `head_len` and `head_ovr` describe the oldest message as of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push one byte of the open message |
| wr_byte | input | DATA_W | Byte to push |
| frame_end | input | 1 | Close the open message |
| release_msg | input | 1 | Drop the oldest message |
| rd_idx | input | log2(BYTE_DEPTH) | Byte offset within the oldest message |
| rd_byte | output | DATA_W | Byte read, one cycle after `rd_idx` |
| head_len | output | log2(BYTE_DEPTH)+1 | Stored length of the oldest message |
| head_ovr | output | 1 | Overrun flag of the oldest message |
| byte_count | output | log2(BYTE_DEPTH)+1 | Bytes held, including the open message |
| msg_count | output | log2(INFO_DEPTH)+1 | Closed messages held |
| fifo_empty | output | 1 | No closed message held |

## Verification
The following properties are checked on every cycle:
- the counts never go past their ring depths;
- a full byte ring stays full until a release or a frame end;
- the message count moves only on a frame end or a release;
- a release on an empty queue leaves both counts alone;
- the oldest message never claims more bytes than are held.

Only the bench scenarios can show that the right bytes come back in order across ring wrap. The same holds for the overrun flag landing on the right message, and for a withdrawn message taking exactly its own bytes with it. A reference queue model in the bench covers these cases.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_DATA_W     = 8;
  localparam int unsigned RXQ_BYTE_DEPTH = 64;
  localparam int unsigned RXQ_INFO_DEPTH = 32;
endpackage

// File: rtl/rxq_byte_ring.sv
module rxq_byte_ring #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_info_ring.sv
module rxq_info_ring #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // small ring with asynchronous read so a release sees the head at once
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo #(
  parameter int unsigned DATA_W     = rxq_pkg::RXQ_DATA_W,
  parameter int unsigned BYTE_DEPTH = rxq_pkg::RXQ_BYTE_DEPTH,
  parameter int unsigned INFO_DEPTH = rxq_pkg::RXQ_INFO_DEPTH,
  localparam int unsigned BAW = $clog2(BYTE_DEPTH),
  localparam int unsigned IAW = $clog2(INFO_DEPTH),
  localparam int unsigned CW  = BAW + 1,
  localparam int unsigned MW  = IAW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              frame_end,
  input  logic              release_msg,
  input  logic [BAW-1:0]    rd_idx,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CW-1:0]     head_len,
  output logic              head_ovr,
  output logic [CW-1:0]     byte_count,
  output logic [MW-1:0]     msg_count,
  output logic              fifo_empty
);
  localparam int unsigned RW = CW + 1;

  logic [BAW-1:0] wr_ptr, rd_ptr;
  logic [IAW-1:0] iwr_ptr, ird_ptr;
  logic [CW-1:0]  byte_cnt, cur_cnt;
  logic [MW-1:0]  msg_cnt;
  logic           cur_ovr;
  logic           rd_mask;
  logic [DATA_W-1:0] ring_q;

  logic           byte_full, info_full, acc, drop, keep, rel, fin_ovr;
  logic [CW-1:0]  fin_len, rel_len, drop_len, head_len_c;
  logic           head_ovr_c;
  logic [RW-1:0]  rec_w, rec_r;

  assign byte_full = (byte_cnt == CW'(BYTE_DEPTH));
  assign info_full = (msg_cnt == MW'(INFO_DEPTH));
  assign acc       = wr_en & ~byte_full;
  assign fin_len   = cur_cnt + CW'(acc);
  assign fin_ovr   = cur_ovr | (wr_en & byte_full);
  assign drop      = frame_end & info_full;
  assign keep      = frame_end & ~info_full;
  assign rel       = release_msg & (msg_cnt != '0);

  assign {head_ovr_c, head_len_c} = rec_r;
  assign rec_w    = {fin_ovr, fin_len};
  assign rel_len  = rel  ? head_len_c : '0;
  assign drop_len = drop ? fin_len    : '0;

  rxq_byte_ring #(.DATA_W(DATA_W), .DEPTH(BYTE_DEPTH), .AW(BAW)) i_bytes (
    .clk  (clk),
    .we   (acc),
    .waddr(wr_ptr),
    .wdata(wr_byte),
    .raddr(rd_ptr + rd_idx),
    .rdata(ring_q)
  );

  rxq_info_ring #(.W(RW), .DEPTH(INFO_DEPTH), .AW(IAW)) i_info (
    .clk  (clk),
    .we   (keep),
    .waddr(iwr_ptr),
    .wdata(rec_w),
    .raddr(ird_ptr),
    .rdata(rec_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      iwr_ptr  <= '0;
      ird_ptr  <= '0;
      byte_cnt <= '0;
      msg_cnt  <= '0;
      cur_cnt  <= '0;
      cur_ovr  <= 1'b0;
      rd_mask  <= 1'b1;
      head_len <= '0;
      head_ovr <= 1'b0;
    end else begin
      wr_ptr   <= wr_ptr + BAW'(acc) - BAW'(drop_len);
      rd_ptr   <= rd_ptr + BAW'(rel_len);
      byte_cnt <= byte_cnt + CW'(acc) - rel_len - drop_len;
      msg_cnt  <= msg_cnt + MW'(keep) - MW'(rel);
      if (keep) iwr_ptr <= iwr_ptr + 1'b1;
      if (rel)  ird_ptr <= ird_ptr + 1'b1;
      if (frame_end) begin
        cur_cnt <= '0;
        cur_ovr <= 1'b0;
      end else begin
        cur_cnt <= fin_len;
        cur_ovr <= fin_ovr;
      end
      rd_mask  <= (msg_cnt == '0);
      head_len <= (msg_cnt == '0) ? '0 : head_len_c;
      head_ovr <= (msg_cnt != '0) & head_ovr_c;
    end
  end

  assign rd_byte    = rd_mask ? '0 : ring_q;
  assign byte_count = byte_cnt;
  assign msg_count  = msg_cnt;
  assign fifo_empty = (msg_cnt == '0);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= CW'(BYTE_DEPTH));
  assert_msg_bound_R8: assert property (@(posedge clk) disable iff (rst)
    msg_cnt <= MW'(INFO_DEPTH));
  assert_full_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_cnt == CW'(BYTE_DEPTH) && !release_msg && !frame_end) |=> byte_cnt == CW'(BYTE_DEPTH));
  assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!frame_end && !release_msg) |=> $stable(msg_cnt));
  assert_empty_release_R5: assert property (@(posedge clk) disable iff (rst)
    (release_msg && msg_cnt == '0 && !wr_en && !frame_end) |=> ($stable(byte_cnt) && $stable(msg_cnt)));
  assert_head_fit_R4: assert property (@(posedge clk) disable iff (rst)
    (msg_cnt != '0) |-> (head_len_c <= byte_cnt));
endmodule

// File: tb/test_rx_msg_fifo.sv
`timescale 1ns/1ps
module test_rx_msg_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       frame_end = 1'b0;
  logic       release_msg = 1'b0;
  logic [5:0] rd_idx = 6'd0;
  logic [7:0] rd_byte;
  logic [6:0] head_len;
  logic       head_ovr;
  logic [6:0] byte_count;
  logic [5:0] msg_count;
  logic       fifo_empty;

  int vectors = 0;
  int fails   = 0;

  byte unsigned mq[$];
  int           lq[$];
  bit           oq[$];
  int           cc = 0;
  bit           co = 1'b0;

  always #2.5 clk = ~clk;

  rx_msg_fifo i_rx_msg_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .frame_end(frame_end), .release_msg(release_msg), .rd_idx(rd_idx),
    .rd_byte(rd_byte), .head_len(head_len), .head_ovr(head_ovr),
    .byte_count(byte_count), .msg_count(msg_count), .fifo_empty(fifo_empty)
  );

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, update the model, compare at the next negedge
  task automatic step(bit wr, byte unsigned d, bit fe, bit rel, int idx, string tag);
    int  e_len, e_rd, fin, rl;
    bit  e_ovr, e_rdv, full, ifull, acc, fo;
    e_len = (lq.size() > 0) ? lq[0] : 0;
    e_ovr = (lq.size() > 0) ? oq[0] : 1'b0;
    e_rdv = (lq.size() == 0) || (idx < mq.size());
    e_rd  = (lq.size() == 0) ? 0 : ((idx < mq.size()) ? int'(mq[idx]) : 0);
    wr_en = wr; wr_byte = d; frame_end = fe; release_msg = rel; rd_idx = 6'(idx);
    @(posedge clk);
    full  = (mq.size() >= 64);
    ifull = (lq.size() == 32);
    acc   = wr && !full;
    fin   = cc + int'(acc);
    fo    = co | (wr && full);
    if (acc) mq.push_back(d);
    if (rel && lq.size() > 0) begin
      rl = lq.pop_front();
      void'(oq.pop_front());
      repeat (rl) void'(mq.pop_front());
    end
    if (fe) begin
      if (!ifull) begin lq.push_back(fin); oq.push_back(fo); end
      else repeat (fin) void'(mq.pop_back());
      cc = 0; co = 1'b0;
    end else begin
      cc = fin; co = fo;
    end
    @(negedge clk);
    chk(tag, "byte_count", int'(byte_count), mq.size());
    chk(tag, "msg_count", int'(msg_count), lq.size());
    chk(tag, "fifo_empty", int'(fifo_empty), int'(lq.size() == 0));
    chk(tag, "head_len", int'(head_len), e_len);
    chk(tag, "head_ovr", int'(head_ovr), int'(e_ovr));
    if (e_rdv) chk(tag, "rd_byte", int'(rd_byte), e_rd);
  endtask

  task automatic idle(int idx, string tag);
    step(1'b0, 8'h00, 1'b0, 1'b0, idx, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "byte_count", int'(byte_count), 0);
    chk("R1", "msg_count", int'(msg_count), 0);
    chk("R1", "fifo_empty", int'(fifo_empty), 1);
    chk("R1", "rd_byte", int'(rd_byte), 0);
    chk("R1", "head_len", int'(head_len), 0);
    // R9 empty reads zero
    idle(3, "R9"); idle(0, "R9");
    // R2 / R3 / R7 one message, last byte together with frame_end
    step(1, 8'hAA, 0, 0, 0, "R2");
    step(1, 8'hBB, 0, 0, 0, "R2");
    step(1, 8'hCC, 0, 0, 0, "R2");
    step(1, 8'hDD, 1, 0, 0, "R3");
    idle(0, "R7");
    for (int k = 0; k < 4; k++) idle(k, "R2");
    idle(0, "R3");
    // R11 write and release together
    step(1, 8'h11, 0, 1, 0, "R11");
    idle(0, "R11");
    step(0, 8'h00, 1, 0, 0, "R4");
    idle(0, "R4");
    // R4 release
    step(0, 8'h00, 0, 1, 0, "R4");
    idle(0, "R4");
    // R5 release on empty
    step(0, 8'h00, 0, 1, 0, "R5");
    step(0, 8'h00, 0, 1, 0, "R5");
    idle(0, "R5");
    // R6 overflow of one long message
    for (int k = 0; k < 70; k++) step(1, 8'(k + 1), 0, 0, 0, "R6");
    step(0, 8'h00, 1, 0, 0, "R6");
    idle(0, "R6"); idle(63, "R6"); idle(5, "R6");
    step(0, 8'h00, 0, 1, 0, "R6");
    idle(0, "R6");
    // R8 record ring full: 33rd message withdrawn
    for (int k = 0; k < 33; k++) step(1, 8'(k + 8'h40), 1, 0, 0, "R8");
    step(1, 8'h77, 0, 0, 0, "R8");
    step(1, 8'h78, 1, 0, 0, "R8");
    idle(0, "R8");
    for (int k = 0; k < 32; k++) step(0, 8'h00, 0, 1, 0, "R8");
    idle(0, "R8");
    // R10 random traffic with wrap
    for (int i = 0; i < 4000; i++) begin
      int ph, wp, rp, ix;
      bit w, f, r;
      ph = (i / 250) % 4;
      wp = (ph == 0) ? 85 : (ph == 1) ? 40 : (ph == 2) ? 70 : 20;
      rp = (ph == 0) ? 5  : (ph == 1) ? 30 : (ph == 2) ? 15 : 40;
      w  = ($urandom_range(99) < wp);
      f  = ($urandom_range(99) < 15);
      r  = ($urandom_range(99) < rp);
      ix = (mq.size() > 0) ? int'($urandom_range(mq.size() - 1)) : 0;
      step(w, 8'($urandom), f, r, ix, "R10");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule